// File: doc/BRIEF.md
# Deterministic Quantum Round Scheduler

This controller paces a group of cores through repeating rounds. Each round has two phases. In the parallel phase every core runs its quantum of fixed length with its stores held back. In the commit phase the cores publish their held stores one at a time, in a fixed order. The result is the same interleaving on every run, whatever the timing of the cores.

During the parallel phase a core may ask to perform an atomic or lock operation. The controller admits only the executing core whose current instruction count is the smallest. A requester that is not at the minimum simply waits. Because a core can synchronise without leaving the parallel phase, the scheduler has no separate serial phase.

A core that is not executing is marked idle. An idle core does not hold back the end of the parallel phase, it takes no part in the minimum search, and it gets no commit turn.

Top module: `quantum_round_sched`

## Requirements
- R1: While reset is held, and on the first cycle after it, every `phase_commit` bit, every `commit_en` bit and every `atomic_grant` bit is 0.
- R2: If, at a clock edge in the parallel phase, every core either has `quantum_done` high or has `core_active` low, then from the next cycle all `phase_commit` bits read 1 (1 means the commit phase, 0 means the parallel phase).
- R3: The parallel phase continues for as long as at least one active core holds `quantum_done` low.
- R4: In the commit phase, `commit_en` has at most one bit set. Turns go to cores in ascending index order, starting with the lowest index. A core keeps its enable until it raises `commit_done`. The enable moves to the next core in the cycle after that.
- R5: A core that was idle at the edge where the commit phase began gets no commit turn.
- R6: On the edge where the last pending core raises `commit_done`, the phase returns to parallel. From the next cycle all `phase_commit` bits and all `commit_en` bits are 0.
- R7: In the parallel phase, one cycle after an edge, `atomic_grant` is one-hot on the active core with the smallest `insn_count`, but only if that core had `atomic_req` high at that edge.
- R8: A requester that is not at the minimum receives no grant. If the minimum core is not requesting, no core is granted.
- R9: When several active cores share the smallest count, the lowest-indexed of them is taken as the minimum.
- R10: Idle cores are left out of the minimum search, even when their count is smaller.
- R11: `atomic_grant` is 0 throughout the commit phase. It is also 0 in the cycle after the edge that ends a parallel phase.
- R12: A `commit_done` from a core that does not hold the commit enable has no effect on `commit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_active | input | N_CORES | 1 = the core is executing, 0 = the core is idle |
| quantum_done | input | N_CORES | The core has finished its quantum for this round |
| atomic_req | input | N_CORES | The core asks to perform an atomic or lock operation |
| insn_count | input | N_CORES*CNT_W | Instruction count of each core; core i occupies bits [i*CNT_W +: CNT_W] |
| commit_done | input | N_CORES | The core has finished publishing its buffered stores |
| phase_commit | output | N_CORES | Phase seen by each core: 1 = commit, 0 = parallel |
| commit_en | output | N_CORES | One-hot permission to publish |
| atomic_grant | output | N_CORES | One-hot atomic grant |

## Verification
Some properties are checked on every cycle:
- at most one commit enable and at most one grant are set;
- no enable is set outside the commit phase, and no grant is set inside it;
- an enable is held until its commit completes;
- the commit phase is entered only after every core was done or idle;
- any grant went to an active requester whose count was no larger than that of any active core.

The bench scenarios are needed for the rest:
- the exact ascending order of commit turns;
- skipping of idle cores;
- return to the parallel phase;
- tie-breaking by index;
- suppression of the grant on the edge that closes the parallel phase;
- that stray commit completions are ignored.

// File: rtl/qrs_pkg.sv
// Package: shared types of the quantum round scheduler.
// Assumes: nothing beyond a single clock domain.
package qrs_pkg;
    typedef enum logic {
        PH_PARALLEL = 1'b0,
        PH_COMMIT   = 1'b1
    } phase_e;
endpackage

// File: rtl/qrs_min_pick.sv
// Module: qrs_min_pick
// Finds the index of the valid lane with the smallest count, using a linear
// chain in ascending lane order. Because the comparison is strict, a tie goes
// to the lower index. Pure combinational logic.
// Assumes: N >= 1. When no lane is valid, found is 0 and idx is 0.
module qrs_min_pick #(
    parameter int N = 4,
    parameter int W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [N*W-1:0]   counts,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    logic [W-1:0]     best_cnt   [N+1];
    logic [IDX_W-1:0] best_idx   [N+1];
    logic             best_found [N+1];

    assign best_cnt[0]   = '0;
    assign best_idx[0]   = '0;
    assign best_found[0] = 1'b0;

    // One chain stage per lane: take lane i if it is valid and strictly smaller.
    for (genvar i = 0; i < N; i++) begin : g_stage
        logic [W-1:0] cnt_i;
        logic         take;
        assign cnt_i = counts[i*W +: W];
        assign take  = valid[i] && (!best_found[i] || (cnt_i < best_cnt[i]));
        assign best_cnt[i+1]   = take ? cnt_i : best_cnt[i];
        assign best_idx[i+1]   = take ? IDX_W'(i) : best_idx[i];
        assign best_found[i+1] = best_found[i] | valid[i];
    end

    assign idx   = best_idx[N];
    assign found = best_found[N];
endmodule

// File: rtl/qrs_atomic_arb.sv
// Module: qrs_atomic_arb
// Registered atomic grant. When allow is high, the grant goes to the active
// core with the smallest instruction count, provided that core is requesting.
// Any other requester waits.
// Assumes: allow is low whenever the parallel phase is not continuing.
module qrs_atomic_arb #(
    parameter int N = 4,
    parameter int W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         allow,
    input  logic [N-1:0] active,
    input  logic [N-1:0] req,
    input  logic [N*W-1:0] counts,
    output logic [N-1:0] grant
);
    logic [IDX_W-1:0] min_idx;
    logic             min_found;

    qrs_min_pick #(.N(N), .W(W)) i_min (
        .valid  (active),
        .counts (counts),
        .idx    (min_idx),
        .found  (min_found)
    );

    // Grant register: one-hot on the minimum core when it is requesting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
        end else if (allow && min_found && req[min_idx]) begin
            grant <= N'(1) << min_idx;
        end else begin
            grant <= '0;
        end
    end

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8: a grant only ever follows an active request.
    p_grant_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~$past(req & active)) == '0);

    for (genvar i = 0; i < N; i++) begin : g_min_chk
        for (genvar j = 0; j < N; j++) begin : g_vs
            // R10: the granted core's count was no larger than any active core's.
            p_grant_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[i] && $past(active[j])) |->
                ($past(counts[i*W +: W]) <= $past(counts[j*W +: W])));
        end
    end
endmodule

// File: rtl/qrs_commit_seq.sv
// Module: qrs_commit_seq
// Commit turn sequencer. On load it captures which cores take part. During
// the commit phase it enables the lowest pending core and holds that enable
// until the core reports done. drained rises when the final turn completes.
// Assumes: load and in_commit are never high together.
module qrs_commit_seq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] snapshot,
    input  logic         in_commit,
    input  logic [N-1:0] done,
    output logic [N-1:0] en,
    output logic         drained
);
    logic [N-1:0] pending;
    logic [N-1:0] lowest;
    logic [N-1:0] finished;

    // Lowest set bit of the pending mask: the core whose turn it is.
    assign lowest   = pending & (~pending + N'(1));
    assign en       = in_commit ? lowest : '0;
    assign finished = en & done;
    assign drained  = in_commit && ((pending & ~finished) == '0);

    // Pending mask: captured on entry, one bit cleared per completed turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (load) begin
            pending <= snapshot;
        end else if (in_commit) begin
            pending <= pending & ~finished;
        end
    end

    p_en_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en));

    for (genvar i = 0; i < N; i++) begin : g_hold
        // R4: an enable without done is still present in the next cycle.
        p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && !done[i]) |=> en[i]);
    end
endmodule

// File: rtl/quantum_round_sched.sv
// Module: quantum_round_sched (top)
// Runs the rounds for N_CORES cores. The parallel phase lasts until every core
// is done or idle. The commit phase grants publishing turns in ascending
// index. The atomic arbiter may grant only while the parallel phase continues.
// Assumes: cores lower quantum_done before the next parallel phase completes.
module quantum_round_sched #(
    parameter int N_CORES = 4,
    parameter int CNT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CORES-1:0]       core_active,
    input  logic [N_CORES-1:0]       quantum_done,
    input  logic [N_CORES-1:0]       atomic_req,
    input  logic [N_CORES*CNT_W-1:0] insn_count,
    input  logic [N_CORES-1:0]       commit_done,
    output logic [N_CORES-1:0]       phase_commit,
    output logic [N_CORES-1:0]       commit_en,
    output logic [N_CORES-1:0]       atomic_grant
);
    import qrs_pkg::*;

    phase_e phase_q;
    logic   in_commit;
    logic   all_ready;
    logic   enter_commit;
    logic   drained;

    assign in_commit    = (phase_q == PH_COMMIT);
    assign all_ready    = &(quantum_done | ~core_active);
    assign enter_commit = !in_commit && all_ready;
    assign phase_commit = {N_CORES{in_commit}};

    // Phase register: move to commit when all are ready, back when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PARALLEL;
        end else if (enter_commit) begin
            phase_q <= PH_COMMIT;
        end else if (drained) begin
            phase_q <= PH_PARALLEL;
        end
    end

    qrs_commit_seq #(.N(N_CORES)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (enter_commit),
        .snapshot  (core_active),
        .in_commit (in_commit),
        .done      (commit_done),
        .en        (commit_en),
        .drained   (drained)
    );

    qrs_atomic_arb #(.N(N_CORES), .W(CNT_W)) i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .allow  (!in_commit && !all_ready),
        .active (core_active),
        .req    (atomic_req),
        .counts (insn_count),
        .grant  (atomic_grant)
    );

    p_enter_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_commit[0]) |-> $past(&(quantum_done | ~core_active)));

    p_en_in_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en != '0) |-> phase_commit[0]);

    p_no_grant_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (atomic_grant != '0) |-> !phase_commit[0]);

    p_leave_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_commit[0]) |-> ($past(commit_en & ~commit_done) == '0));
endmodule

// File: tb/test_quantum_round_sched.sv
module test_quantum_round_sched;
    localparam int N = 4;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   core_active = '1;
    logic [N-1:0]   quantum_done = '0;
    logic [N-1:0]   atomic_req = '0;
    logic [N*W-1:0] insn_count = '0;
    logic [N-1:0]   commit_done = '0;
    logic [N-1:0]   phase_commit;
    logic [N-1:0]   commit_en;
    logic [N-1:0]   atomic_grant;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    quantum_round_sched #(.N_CORES(N), .CNT_W(W)) i_quantum_round_sched (
        .clk(clk), .rst_n(rst_n), .core_active(core_active),
        .quantum_done(quantum_done), .atomic_req(atomic_req),
        .insn_count(insn_count), .commit_done(commit_done),
        .phase_commit(phase_commit), .commit_en(commit_en),
        .atomic_grant(atomic_grant)
    );

    typedef struct packed {
        logic [3:0]   act;
        logic [3:0]   req;
        logic [127:0] cnt;   // {core3, core2, core1, core0}
        logic [3:0]   exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'hF, 4'hF, {32'd40, 32'd30, 32'd20, 32'd50}, 4'b0010},  // R7
        '{4'hF, 4'hD, {32'd40, 32'd30, 32'd20, 32'd50}, 4'b0000},  // R8
        '{4'hF, 4'h1, {32'd40, 32'd30, 32'd20, 32'd50}, 4'b0000},  // R8
        '{4'hF, 4'h6, {32'd90, 32'd15, 32'd15, 32'd70}, 4'b0010},  // R9
        '{4'hC, 4'h8, {32'd5,  32'd9,  32'd2,  32'd1},  4'b1000},  // R10
        '{4'hD, 4'h1, {32'd9,  32'd9,  32'd3,  32'd8},  4'b0001},  // R10
        '{4'hF, 4'h8, {32'd5,  32'd5,  32'd5,  32'd5},  4'b0000},  // R9
        '{4'hF, 4'h1, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0}, 4'b0001}  // R7
    };

    task automatic chk(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: outputs while reset is held
        repeat (3) tick();
        chk("R1", "phase in reset", phase_commit, 4'b0000);
        chk("R1", "enable in reset", commit_en, 4'b0000);
        chk("R1", "grant in reset", atomic_grant, 4'b0000);
        rst_n = 1'b1;
        tick();
        chk("R1", "phase after reset", phase_commit, 4'b0000);

        // Arbitration table: R7 R8 R9 R10
        for (int k = 0; k < 8; k++) begin
            core_active = VECS[k].act;
            atomic_req  = VECS[k].req;
            insn_count  = VECS[k].cnt;
            tick();
            chk("R7-table", $sformatf("vector %0d grant", k), atomic_grant, VECS[k].exp);
        end
        atomic_req  = '0;
        core_active = 4'hF;
        tick();

        // R3: one active core is not yet done
        quantum_done = 4'b0111;
        tick();
        tick();
        chk("R3", "still parallel", phase_commit, 4'b0000);

        // R2: every core is done
        quantum_done = 4'b1111;
        tick();
        chk("R2", "enter commit", phase_commit, 4'b1111);
        chk("R4", "first turn", commit_en, 4'b0001);
        quantum_done = '0;
        atomic_req = 4'b0001;
        insn_count = '0;
        tick();
        chk("R4", "turn held", commit_en, 4'b0001);
        chk("R11", "no grant in commit", atomic_grant, 4'b0000);
        atomic_req = '0;

        // R12: a done from a core without the enable is ignored
        commit_done = 4'b0100;
        tick();
        chk("R12", "stray done", commit_en, 4'b0001);

        // R4: turns advance in ascending order
        commit_done = 4'b0001;
        tick();
        chk("R4", "second turn", commit_en, 4'b0010);
        commit_done = 4'b0010;
        tick();
        chk("R4", "third turn", commit_en, 4'b0100);
        commit_done = 4'b0100;
        tick();
        chk("R4", "fourth turn", commit_en, 4'b1000);
        commit_done = 4'b1000;
        tick();
        commit_done = '0;
        chk("R6", "back to parallel", phase_commit, 4'b0000);
        chk("R6", "no enable", commit_en, 4'b0000);

        // R5: idle cores 0 and 2 are skipped
        core_active = 4'b1010;
        quantum_done = 4'b1010;
        tick();
        chk("R5", "enter commit", phase_commit, 4'b1111);
        chk("R5", "first turn is core1", commit_en, 4'b0010);
        quantum_done = '0;
        commit_done = 4'b0010;
        tick();
        chk("R5", "next turn is core3", commit_en, 4'b1000);
        commit_done = 4'b1000;
        tick();
        commit_done = '0;
        chk("R6", "back to parallel", phase_commit, 4'b0000);

        // R11: a request on the edge that closes the parallel phase
        core_active = 4'hF;
        atomic_req = 4'b0001;
        insn_count = {32'd9, 32'd9, 32'd9, 32'd1};
        quantum_done = 4'hF;
        tick();
        chk("R11", "no grant at phase end", atomic_grant, 4'b0000);
        atomic_req = '0;
        quantum_done = '0;
        for (int c = 0; c < N; c++) begin
            commit_done = 4'b0001 << c;
            tick();
        end
        commit_done = '0;
        chk("R6", "round finished", phase_commit, 4'b0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule